// File: doc/BRIEF.md
# Potentiometer register bus slave

This block is the serial-bus front end of a digital potentiometer's register file. It takes the raw clock and data lines of a two-wire I2C bus and cleans both lines on the system clock. It recognises START, repeated START and STOP, and takes part in a transfer only when the address byte names this device. The address has a fixed five-bit prefix, and the two remaining bits come from two strap pins. The block drives the data line only low, through an output enable.

In a write, the byte after the address byte loads a persistent memory pointer. Each further byte is handed to the register file as a one-cycle write strobe that carries the pointer and the data, and the pointer then advances. A read fetches bytes from the register file at the current pointer. A dummy write of the pointer followed by a repeated START therefore selects what a later read returns.

Two single-cycle event pulses tell the register side that a transfer which wrote data has ended, one for STOP and one for repeated START. The register side uses the STOP event to start a slow commit. While that commit runs it holds the busy input, and the block then refuses its own address so that the master can poll.

Top module: `potreg_i2c_slave`

## Requirements
- R1: The device answers the address byte {5'b01010, A1, A0, rw}, with A1 on strap_i[1], A0 on strap_i[0] and rw in bit 0 (0 = write, 1 = read). It acknowledges by pulling SDA low during the ninth clock of that byte.
- R2: After an address byte that does not match, the block acknowledges nothing, issues no strobe and no event, and drives SDA for nothing until the next START.
- R3: In a write transfer, the first byte after the address byte loads the memory pointer. Every later byte is acknowledged and produces one wr_stb_o pulse, with wr_addr_o equal to the pointer and wr_data_o equal to the byte (MSB received first).
- R4: The pointer increments by one after every data byte written or read. rd_addr_o always shows its value.
- R5: A read transfer that is not preceded by a pointer byte returns the byte at the current pointer. rd_req_o pulses each time a byte is fetched from rd_data_i.
- R6: A pointer write followed by a repeated START and a read address byte makes the read return the location just written to the pointer.
- R7: Read bytes are sent MSB first. A master ACK (0) on the ninth bit fetches the next location. A master NACK (1) ends the read with SDA released.
- R8: While busy_i is high when the address byte completes, the address is not acknowledged and the transfer is ignored.
- R9: A pulse on SCL or SDA shorter than STABLE_CYC system clocks (52 ns at the default setting and a 4 ns clock) has no effect on the bus state.
- R10: A STOP ends a transfer that wrote at least one data byte with one evt_stop_o pulse, and a repeated START ends it with one evt_rstart_o pulse. A transfer without a data write gives neither.
- R11: sda_oe_o is 0 out of reset, and it is only ever asserted in a cycle where the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| strap_i | input | 2 | Address strap bits {A1, A0} |
| busy_i | input | 1 | Register side is committing; refuse the address |
| wr_stb_o | output | 1 | One-cycle write strobe |
| wr_addr_o | output | 8 | Write location, valid with the strobe |
| wr_data_o | output | 8 | Write data, valid with the strobe |
| rd_req_o | output | 1 | One-cycle read fetch pulse |
| rd_addr_o | output | 8 | Current memory pointer |
| rd_data_i | input | 8 | Read data for rd_addr_o, sampled with rd_req_o |
| evt_stop_o | output | 1 | STOP ended a transfer that wrote data |
| evt_rstart_o | output | 1 | Repeated START ended a transfer that wrote data |

## Verification
The address decision and the busy check share one clock edge, the filtered SCL fall after the eighth address bit. The bench holds busy high across a whole address byte and expects a NACK. It then drops busy and expects the same byte to be acknowledged, with nothing stored in between. A repeated START also collides with data reception: the SCL rise that precedes it shifts one stray bit into a partly received byte. The bench judges this by requiring no extra write strobe, exactly one repeated-START event, and a correct read of the pointer that the preceding write left behind.

// File: rtl/potreg_i2c_pkg.sv
package potreg_i2c_pkg;

  localparam int BYTE_W = 8;
  localparam int BITCNT_W = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK
  } slv_state_e;

endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int STABLE_CYC  = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);

  localparam int CW = $clog2(STABLE_CYC + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sync_s;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   out_q, out_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
  end

  assign sync_s = sync_q[SYNC_STAGES-1];

  // The output follows the synchronised line only once it has differed
  // for STABLE_CYC consecutive cycles.
  always_comb begin
    cnt_d = cnt_q;
    out_d = out_q;
    if (sync_s == out_q) begin
      cnt_d = '0;
    end else if (cnt_q == CW'(STABLE_CYC - 1)) begin
      out_d = sync_s;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign line_o = out_q;

endmodule

// File: rtl/i2c_bus_conditions.sv
module i2c_bus_conditions (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);

  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign bus_start = scl_f & scl_q & sda_q & ~sda_f;
  assign bus_stop  = scl_f & scl_q & ~sda_q & sda_f;

endmodule

// File: rtl/potreg_i2c_slave.sv
module potreg_i2c_slave
  import potreg_i2c_pkg::*;
#(
  parameter int           SYNC_STAGES = 2,
  parameter int           STABLE_CYC  = 13,
  parameter logic [4:0]   DEV_ID      = 5'b01010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [1:0]        strap_i,
  input  logic              busy_i,
  output logic              wr_stb_o,
  output logic [BYTE_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              rd_req_o,
  output logic [BYTE_W-1:0] rd_addr_o,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              evt_stop_o,
  output logic              evt_rstart_o
);

  localparam int NLINES = 2;
  localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(BYTE_W);

  // line filtering: index 1 = SCL, index 0 = SDA
  logic [NLINES-1:0] raw_lines, flt_lines;
  logic              scl_flt, sda_flt;

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2c_glitch_filter #(
      .SYNC_STAGES (SYNC_STAGES),
      .STABLE_CYC  (STABLE_CYC)
    ) u_flt (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (raw_lines[g]),
      .line_o (flt_lines[g])
    );
  end

  assign scl_flt = flt_lines[1];
  assign sda_flt = flt_lines[0];

  logic scl_rise, scl_fall, bus_start, bus_stop;

  i2c_bus_conditions u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_f     (scl_flt),
    .sda_f     (sda_flt),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop)
  );

  logic [6:0] own_addr;
  assign own_addr = {DEV_ID, strap_i};

  slv_state_e          st_q, st_d;
  logic [BITCNT_W-1:0] cnt_q, cnt_d;
  logic [BYTE_W-1:0]   rx_q, rx_d;
  logic [BYTE_W-1:0]   tx_q, tx_d;
  logic [BYTE_W-1:0]   ptr_q, ptr_d;
  logic [BYTE_W-1:0]   waddr_q, waddr_d;
  logic [BYTE_W-1:0]   wdat_q, wdat_d;
  logic                rw_q, rw_d;
  logic                mack_q, mack_d;
  logic                oe_q, oe_d;
  logic                wrote_q, wrote_d;
  logic                wstb_q, wstb_d;
  logic                rreq_q, rreq_d;
  logic                estop_q, estop_d;
  logic                ers_q, ers_d;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    rx_d    = rx_q;
    tx_d    = tx_q;
    ptr_d   = ptr_q;
    waddr_d = waddr_q;
    wdat_d  = wdat_q;
    rw_d    = rw_q;
    mack_d  = mack_q;
    oe_d    = oe_q;
    wrote_d = wrote_q;
    wstb_d  = 1'b0;
    rreq_d  = 1'b0;
    estop_d = 1'b0;
    ers_d   = 1'b0;

    if (bus_start) begin
      st_d    = ST_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
      wrote_d = 1'b0;
      ers_d   = wrote_q;
    end else if (bus_stop) begin
      st_d    = ST_IDLE;
      oe_d    = 1'b0;
      wrote_d = 1'b0;
      estop_d = wrote_q;
    end else if (scl_rise) begin
      unique case (st_q)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          rx_d  = {rx_q[BYTE_W-2:0], sda_flt};
          cnt_d = cnt_q + BITCNT_W'(1);
        end
        ST_RDATA:     cnt_d  = cnt_q + BITCNT_W'(1);
        ST_RDATA_ACK: mack_d = sda_flt;
        default: ;
      endcase
    end else if (scl_fall) begin
      unique case (st_q)
        ST_ADDR: begin
          if (cnt_q == LAST_BIT) begin
            if ((rx_q[BYTE_W-1:1] == own_addr) && !busy_i) begin
              st_d = ST_ADDR_ACK;
              oe_d = 1'b1;
              rw_d = rx_q[0];
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          cnt_d = '0;
          if (rw_q) begin
            st_d   = ST_RDATA;
            rreq_d = 1'b1;
            tx_d   = rd_data_i;
            oe_d   = ~rd_data_i[BYTE_W-1];
          end else begin
            st_d = ST_PTR;
            oe_d = 1'b0;
          end
        end
        ST_PTR: begin
          if (cnt_q == LAST_BIT) begin
            ptr_d = rx_q;
            oe_d  = 1'b1;
            st_d  = ST_PTR_ACK;
          end
        end
        ST_WDATA: begin
          if (cnt_q == LAST_BIT) begin
            wstb_d  = 1'b1;
            waddr_d = ptr_q;
            wdat_d  = rx_q;
            ptr_d   = ptr_q + BYTE_W'(1);
            wrote_d = 1'b1;
            oe_d    = 1'b1;
            st_d    = ST_WDATA_ACK;
          end
        end
        ST_PTR_ACK, ST_WDATA_ACK: begin
          oe_d  = 1'b0;
          cnt_d = '0;
          st_d  = ST_WDATA;
        end
        ST_RDATA: begin
          if (cnt_q == LAST_BIT) begin
            oe_d  = 1'b0;
            ptr_d = ptr_q + BYTE_W'(1);
            st_d  = ST_RDATA_ACK;
          end else begin
            tx_d = {tx_q[BYTE_W-2:0], 1'b0};
            oe_d = ~tx_q[BYTE_W-2];
          end
        end
        ST_RDATA_ACK: begin
          if (!mack_q) begin
            st_d   = ST_RDATA;
            cnt_d  = '0;
            rreq_d = 1'b1;
            tx_d   = rd_data_i;
            oe_d   = ~rd_data_i[BYTE_W-1];
          end else begin
            st_d = ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      waddr_q <= '0;
      wdat_q  <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b1;
      oe_q    <= 1'b0;
      wrote_q <= 1'b0;
      wstb_q  <= 1'b0;
      rreq_q  <= 1'b0;
      estop_q <= 1'b0;
      ers_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      rx_q    <= rx_d;
      tx_q    <= tx_d;
      ptr_q   <= ptr_d;
      waddr_q <= waddr_d;
      wdat_q  <= wdat_d;
      rw_q    <= rw_d;
      mack_q  <= mack_d;
      oe_q    <= oe_d;
      wrote_q <= wrote_d;
      wstb_q  <= wstb_d;
      rreq_q  <= rreq_d;
      estop_q <= estop_d;
      ers_q   <= ers_d;
    end
  end

  assign sda_oe_o     = oe_q;
  assign wr_stb_o     = wstb_q;
  assign wr_addr_o    = waddr_q;
  assign wr_data_o    = wdat_q;
  assign rd_req_o     = rreq_q;
  assign rd_addr_o    = ptr_q;
  assign evt_stop_o   = estop_q;
  assign evt_rstart_o = ers_q;

endmodule

// File: rtl/potreg_i2c_slave_chk.sv
module potreg_i2c_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_f,
  input logic       sda_oe_o,
  input logic       wr_stb_o,
  input logic [7:0] wr_addr_o,
  input logic [7:0] wr_data_o,
  input logic       rd_req_o,
  input logic [7:0] rd_addr_o,
  input logic       evt_stop_o,
  input logic       evt_rstart_o
);

  a_r11_oe_asserts_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_f);

  a_r7_fetch_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> !scl_f);

  a_r4_ptr_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> (rd_addr_o == wr_addr_o + 8'd1));

  a_r3_one_pulse_kind: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_stb_o, rd_req_o, evt_stop_o, evt_rstart_o}));

  a_r3_wdata_held: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb_o |-> ($stable(wr_data_o) && $stable(wr_addr_o)));

  a_r10_event_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_stop_o || evt_rstart_o) |-> scl_f);

endmodule

bind potreg_i2c_slave potreg_i2c_slave_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .scl_f        (scl_flt),
  .sda_oe_o     (sda_oe_o),
  .wr_stb_o     (wr_stb_o),
  .wr_addr_o    (wr_addr_o),
  .wr_data_o    (wr_data_o),
  .rd_req_o     (rd_req_o),
  .rd_addr_o    (rd_addr_o),
  .evt_stop_o   (evt_stop_o),
  .evt_rstart_o (evt_rstart_o)
);

// File: tb/potreg_i2c_slave_bench.sv
module potreg_i2c_slave_bench;

  localparam int Q = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [1:0] strap = 2'b00;
  logic       busy  = 1'b0;
  logic       sda_oe, sda_bus;
  logic       wr_stb, rd_req, evt_stop, evt_rs;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;

  assign sda_bus = sda_m & ~sda_oe;
  assign rd_data = rd_addr ^ 8'hA5;

  potreg_i2c_slave u_potreg_i2c_slave (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl_m),
    .sda_i        (sda_bus),
    .sda_oe_o     (sda_oe),
    .strap_i      (strap),
    .busy_i       (busy),
    .wr_stb_o     (wr_stb),
    .wr_addr_o    (wr_addr),
    .wr_data_o    (wr_data),
    .rd_req_o     (rd_req),
    .rd_addr_o    (rd_addr),
    .rd_data_i    (rd_data),
    .evt_stop_o   (evt_stop),
    .evt_rstart_o (evt_rs)
  );

  int n_wr = 0, n_stop = 0, n_rs = 0;
  logic [7:0] last_wa = 8'h00, last_wd = 8'h00;

  always @(posedge clk) begin
    if (wr_stb) begin
      n_wr    <= n_wr + 1;
      last_wa <= wr_addr;
      last_wd <= wr_data;
    end
    if (evt_stop) n_stop <= n_stop + 1;
    if (evt_rs)   n_rs   <= n_rs + 1;
  end

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  // gkind 1: SDA pulse while SCL high, 2: SCL low pulse while SCL high
  task automatic send_bit(input logic b, input int gkind);
    sda_m = b; wq(Q); scl_m = 1'b1; wq(5);
    if (gkind == 1) begin
      sda_m = ~b; wq(10); sda_m = b;
    end else if (gkind == 2) begin
      scl_m = 1'b0; wq(10); scl_m = 1'b1;
    end else begin
      wq(10);
    end
    wq(2*Q - 15); scl_m = 1'b0; wq(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, input int gpos, input int gkind,
                         output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i], (i == gpos) ? gkind : 0);
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); ack = sda_bus; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic rd_byte(input logic nack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); d[i] = sda_bus; wq(Q); scl_m = 1'b0; wq(Q);
    end
    send_bit(nack, 0);
  endtask

  task automatic t_reset();
    check("R11 oe after reset", sda_oe, 0);
    check("R3 no strobe after reset", wr_stb, 0);
    check("R4 pointer after reset", rd_addr, 8'h00);
  endtask

  task automatic t_write_single();
    logic a0, a1, a2;
    bus_start();
    wr_byte(8'h50, -1, 0, a0);
    wr_byte(8'h02, -1, 0, a1);
    wr_byte(8'h5A, -1, 0, a2);
    check("R1 address ack", a0, 0);
    check("R3 pointer ack", a1, 0);
    check("R3 data ack", a2, 0);
    check("R3 strobe count", n_wr, 1);
    check("R3 strobe addr", last_wa, 8'h02);
    check("R3 strobe data", last_wd, 8'h5A);
    check("R4 pointer advanced", rd_addr, 8'h03);
    bus_stop();
    check("R10 stop event", n_stop, 1);
  endtask

  task automatic t_write_burst();
    logic a;
    bus_start();
    wr_byte(8'h50, -1, 0, a);
    wr_byte(8'h10, -1, 0, a);
    wr_byte(8'h11, -1, 0, a);
    wr_byte(8'h22, -1, 0, a);
    wr_byte(8'h33, -1, 0, a);
    check("R4 burst count", n_wr, 4);
    check("R4 burst last addr", last_wa, 8'h12);
    check("R4 burst last data", last_wd, 8'h33);
    check("R4 burst pointer", rd_addr, 8'h13);
    bus_stop();
    check("R10 burst stop event", n_stop, 2);
  endtask

  task automatic t_read_current();
    logic a;
    logic [7:0] d;
    bus_start();
    wr_byte(8'h51, -1, 0, a);
    check("R1 read address ack", a, 0);
    rd_byte(1'b0, d);
    check("R5 read at pointer", d, 8'h13 ^ 8'hA5);
    rd_byte(1'b1, d);
    check("R7 next after ack", d, 8'h14 ^ 8'hA5);
    check("R7 released after nack", sda_oe, 0);
    check("R4 pointer after reads", rd_addr, 8'h15);
    bus_stop();
    check("R10 no stop event on read", n_stop, 2);
  endtask

  task automatic t_dummy_write();
    logic a;
    logic [7:0] d;
    bus_start();
    wr_byte(8'h50, -1, 0, a);
    wr_byte(8'h00, -1, 0, a);
    bus_start();
    check("R10 no rstart event without data", n_rs, 0);
    wr_byte(8'h51, -1, 0, a);
    rd_byte(1'b1, d);
    check("R6 dummy write selects location", d, 8'h00 ^ 8'hA5);
    bus_stop();
    bus_start();
    wr_byte(8'h50, -1, 0, a);
    wr_byte(8'h00, -1, 0, a);
    wr_byte(8'h40, -1, 0, a);
    bus_start();
    check("R10 rstart event after write", n_rs, 1);
    check("R10 no stop event on rstart", n_stop, 2);
    check("R3 rstart cut no extra strobe", n_wr, 5);
    wr_byte(8'h51, -1, 0, a);
    rd_byte(1'b1, d);
    check("R6 read after write and rstart", d, 8'h01 ^ 8'hA5);
    bus_stop();
    check("R10 read stop no event", n_stop, 2);
  endtask

  task automatic t_mismatch();
    logic a0, a1, a2, a3;
    bus_start();
    wr_byte(8'h56, -1, 0, a0);
    wr_byte(8'h00, -1, 0, a1);
    wr_byte(8'h33, -1, 0, a2);
    bus_stop();
    check("R2 foreign address nack", a0, 1);
    check("R2 later byte ignored", a1, 1);
    check("R2 data byte ignored", a2, 1);
    check("R2 no strobe", n_wr, 5);
    check("R2 no event", n_stop, 2);
    bus_start();
    wr_byte(8'h53, -1, 0, a3);
    bus_stop();
    check("R2 foreign read nack", a3, 1);
  endtask

  task automatic t_strap();
    logic a0, a1;
    strap = 2'b10;
    wq(Q);
    bus_start();
    wr_byte(8'h50, -1, 0, a0);
    bus_stop();
    check("R1 old address refused with A1 set", a0, 1);
    bus_start();
    wr_byte(8'h54, -1, 0, a1);
    wr_byte(8'h05, -1, 0, a0);
    wr_byte(8'h77, -1, 0, a0);
    bus_stop();
    check("R1 strap address acked", a1, 0);
    check("R1 strap write addr", last_wa, 8'h05);
    check("R1 strap write data", last_wd, 8'h77);
    strap = 2'b00;
    wq(Q);
  endtask

  task automatic t_busy();
    logic a;
    int base;
    base = n_wr;
    busy = 1'b1;
    bus_start();
    wr_byte(8'h50, -1, 0, a);
    check("R8 busy refuses address", a, 1);
    wr_byte(8'h20, -1, 0, a);
    bus_stop();
    check("R8 busy no strobe", n_wr, base);
    busy = 1'b0;
    bus_start();
    wr_byte(8'h50, -1, 0, a);
    check("R8 ack once idle", a, 0);
    wr_byte(8'h20, -1, 0, a);
    wr_byte(8'h9C, -1, 0, a);
    bus_stop();
    check("R8 write after busy", last_wd, 8'h9C);
  endtask

  task automatic t_glitch();
    logic a;
    int base_w, base_s;
    base_w = n_wr;
    base_s = n_stop;
    bus_start();
    wr_byte(8'h50, -1, 0, a);
    wr_byte(8'h30, -1, 0, a);
    wr_byte(8'h81, 5, 1, a);
    check("R9 sda pulse no stop", n_stop, base_s);
    check("R9 sda pulse data", last_wd, 8'h81);
    check("R9 sda pulse addr", last_wa, 8'h30);
    wr_byte(8'h00, 3, 2, a);
    check("R9 scl pulse ack", a, 0);
    check("R9 scl pulse data", last_wd, 8'h00);
    check("R9 scl pulse addr", last_wa, 8'h31);
    check("R9 strobe count", n_wr, base_w + 2);
    bus_stop();
    check("R11 released after stop", sda_oe, 0);
  endtask

  initial begin
    wq(5);
    rst_n = 1'b1;
    wq(5);
    t_reset();
    t_write_single();
    t_write_burst();
    t_read_current();
    t_dummy_write();
    t_mismatch();
    t_strap();
    t_busy();
    t_glitch();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule